// File: doc/BRIEF.md
# Configurable Four-Macrocell Logic Block

This block is the basic logic cell of a complex programmable logic device. Eighteen input signals feed a programmable AND array that forms product terms. Each term is set by a mask with one true and one complement bit per input. Twenty of the terms feed four macrocells, five per macrocell. A macrocell ORs four of its terms together. In bypass mode that sum goes out as it is. In wide mode the sum is XORed with the macrocell's fifth term, which sets the output polarity. Each macrocell output is either combinatorial or taken from a register.

Three further terms control the block. The first is a clock term, used when the block clocks its registers from its own logic. The second is a reset term that clears the registers. The third is an output-enable term that is sent straight to the pin cells. The registers share one clock choice for the whole block. It is either one of three dedicated clock lines, modelled as synchronous enables, or the rising edge of the clock term as sampled on the system clock. An active-low global reset also clears the registers. The configuration is a single static vector, captured whole through a load strobe.

Top module: `plb_block`

## Requirements
- R1: A term is high only when every literal set in its mask holds. Mask bit 2i selects input i true, and bit 2i+1 selects input i complemented. A term whose mask is all zero is unused and reads low.
- R2: In bypass mode (wide bit 0), a macrocell's logic value is the OR of its four sum terms. For macrocell m these are terms 5m to 5m+3. Its XOR term, 5m+4, has no effect.
- R3: In wide mode (wide bit 1), the logic value is the OR of the four sum terms XORed with term 5m+4.
- R4: A macrocell whose reg_mode bit is 0 drives its logic value onto its output in the same cycle, with no clock edge in between.
- R5: A macrocell whose reg_mode bit is 1 outputs its register. The register loads the logic value on a clock edge where the block's capture condition is true. Otherwise it holds.
- R6: Clock select codes 0, 1 and 2 make the capture condition equal to y_en bit 0, 1 or 2. The other y_en bits are ignored.
- R7: Clock select code 3 captures on an edge where the clock term (term 20) is high and was low at the previous edge. While the term stays high, no further capture happens.
- R8: glob_rst_n low clears all four registers at the next edge, even when a capture is due.
- R9: The reset term (term 21) high clears all four registers at the next edge.
- R10: oe_out follows the output-enable term (term 22) combinatorially.
- R11: rst clears the configuration to all zero and clears the registers. cfg_load captures cfg_in at the next edge. Until then the old configuration stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_rst_n | input | 1 | Active-low global register reset |
| cfg_load | input | 1 | Captures cfg_in into the configuration register |
| cfg_in | input | 838 | Configuration vector: clock select, reg_mode, wide mode, 23 term masks |
| din | input | 18 | Block inputs to the AND array |
| y_en | input | 3 | Dedicated clock lines, modelled as enables |
| mc_out | output | 4 | Macrocell outputs |
| oe_out | output | 1 | Output-enable term to the pin cells |

## Verification
Combinatorial outputs and oe_out respond to din without waiting for a clock edge. The bench checks them one time unit after it drives new inputs at the falling edge. Registered outputs, configuration loads and both register resets take effect at the first rising edge after the stimulus. The bench's model updates its registers at that same edge, and the check is made on the following falling edge. The clock-term capture also depends on the term's value at the previous edge, so the model keeps its own copy of that sample.

// File: rtl/plb_pkg.sv
package plb_pkg;
    localparam int NUM_IN      = 18;
    localparam int NUM_MC      = 4;
    localparam int OR_PER_MC   = 4;
    localparam int PT_PER_MC   = OR_PER_MC + 1;
    localparam int NUM_LOGIC   = NUM_MC * PT_PER_MC;
    localparam int PT_CK       = NUM_LOGIC;
    localparam int PT_RST      = NUM_LOGIC + 1;
    localparam int PT_OE       = NUM_LOGIC + 2;
    localparam int NUM_PT      = NUM_LOGIC + 3;
    localparam int MASK_W      = 2 * NUM_IN;
    localparam int NUM_Y       = 3;

    typedef enum logic [1:0] {
        CK_Y0 = 2'd0,
        CK_Y1 = 2'd1,
        CK_Y2 = 2'd2,
        CK_PT = 2'd3
    } ck_sel_e;

    typedef logic [MASK_W-1:0] pt_mask_t;

    typedef struct packed {
        ck_sel_e                 ck_sel;
        logic [NUM_MC-1:0]       reg_mode;
        logic [NUM_MC-1:0]       wide_mode;
        pt_mask_t [NUM_PT-1:0]   masks;
    } plb_cfg_t;

    localparam int CFG_W = $bits(plb_cfg_t);
endpackage

// File: rtl/plb_and_array.sv
module plb_and_array
    import plb_pkg::*;
(
    input  pt_mask_t [NUM_PT-1:0] masks,
    input  logic [NUM_IN-1:0]     din,
    output logic [NUM_PT-1:0]     pt
);
    for (genvar g = 0; g < NUM_PT; g++) begin : g_term
        logic t;
        always_comb begin
            t = |masks[g];
            for (int i = 0; i < NUM_IN; i++) begin
                if (masks[g][2*i] && !din[i])
                    t = 1'b0;
                if (masks[g][2*i+1] && din[i])
                    t = 1'b0;
            end
        end
        assign pt[g] = t;

        // R1: an unused term never reaches the array output high
        always_comb begin
            if (masks[g] == '0)
                p_unused_low_r1: assert (pt[g] == 1'b0);
        end
    end
endmodule

// File: rtl/plb_clk_ctl.sv
module plb_clk_ctl
    import plb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ck_sel_e          ck_sel,
    input  logic [NUM_Y-1:0] y_en,
    input  logic             pt_ck,
    output logic             cap
);
    logic ck_prev;

    always_ff @(posedge clk) begin
        if (rst)
            ck_prev <= 1'b0;
        else
            ck_prev <= pt_ck;
    end

    always_comb begin
        case (ck_sel)
            CK_Y0:   cap = y_en[0];
            CK_Y1:   cap = y_en[1];
            CK_Y2:   cap = y_en[2];
            default: cap = pt_ck & ~ck_prev;
        endcase
    end

    // R7: a term-clock capture only ever happens on a low-to-high step
    p_pt_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (ck_sel == CK_PT && cap) |-> (pt_ck && !$past(pt_ck)));
endmodule

// File: rtl/plb_macrocell.sv
module plb_macrocell
    import plb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OR_PER_MC-1:0] or_pt,
    input  logic                 xor_pt,
    input  logic                 wide,
    input  logic                 reg_mode,
    input  logic                 cap,
    input  logic                 clr,
    output logic                 mc_out
);
    logic sum;
    logic d;
    logic q;

    assign sum    = |or_pt;
    assign d      = wide ? (sum ^ xor_pt) : sum;
    assign mc_out = reg_mode ? q : d;

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (cap)
            q <= d;
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (cap && !clr) |=> (q == $past(d)));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!cap && !clr) |=> $stable(q));
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == 1'b0));
endmodule

// File: rtl/plb_block.sv
module plb_block
    import plb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              glob_rst_n,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic [NUM_IN-1:0] din,
    input  logic [NUM_Y-1:0]  y_en,
    output logic [NUM_MC-1:0] mc_out,
    output logic              oe_out
);
    plb_cfg_t          cfg_q;
    logic [NUM_PT-1:0] pt;
    logic              cap;
    logic              clr;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_load)
            cfg_q <= cfg_in;
    end

    plb_and_array u_array (
        .masks (cfg_q.masks),
        .din   (din),
        .pt    (pt)
    );

    plb_clk_ctl u_clk (
        .clk    (clk),
        .rst    (rst),
        .ck_sel (cfg_q.ck_sel),
        .y_en   (y_en),
        .pt_ck  (pt[PT_CK]),
        .cap    (cap)
    );

    assign clr    = ~glob_rst_n | pt[PT_RST];
    assign oe_out = pt[PT_OE];

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        plb_macrocell u_mc (
            .clk      (clk),
            .rst      (rst),
            .or_pt    (pt[m*PT_PER_MC +: OR_PER_MC]),
            .xor_pt   (pt[m*PT_PER_MC + OR_PER_MC]),
            .wide     (cfg_q.wide_mode[m]),
            .reg_mode (cfg_q.reg_mode[m]),
            .cap      (cap),
            .clr      (clr),
            .mc_out   (mc_out[m])
        );
    end

    // R8: global reset leaves every registered output low after the edge
    p_glob_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (!glob_rst_n && !cfg_load) |=> ((mc_out & cfg_q.reg_mode) == '0));
endmodule

// File: tb/sim_plb_block.sv
`timescale 1ns/1ps
module sim_plb_block;
    import plb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              glob_rst_n = 1'b1;
    logic              cfg_load = 1'b0;
    plb_cfg_t          cfg_in = '0;
    logic [NUM_IN-1:0] din = '0;
    logic [NUM_Y-1:0]  y_en = '0;
    logic [NUM_MC-1:0] mc_out;
    logic              oe_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    plb_cfg_t          cfg_m = '0;
    logic [NUM_MC-1:0] q_m = '0;
    bit                prev_m = 0;

    always #2 clk = ~clk;

    plb_block u0 (
        .clk(clk), .rst(rst), .glob_rst_n(glob_rst_n), .cfg_load(cfg_load),
        .cfg_in(cfg_in), .din(din), .y_en(y_en), .mc_out(mc_out), .oe_out(oe_out)
    );

    function automatic bit b_term(logic [MASK_W-1:0] mk, logic [NUM_IN-1:0] x);
        if (mk == '0) return 0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (mk[2*i] && !x[i]) return 0;
            if (mk[2*i+1] && x[i]) return 0;
        end
        return 1;
    endfunction

    function automatic bit b_logic(plb_cfg_t c, int m, logic [NUM_IN-1:0] x);
        bit s = 0;
        for (int k = 0; k < 4; k++) s |= b_term(c.masks[m*5+k], x);
        if (c.wide_mode[m]) s ^= b_term(c.masks[m*5+4], x);
        return s;
    endfunction

    function automatic logic [MASK_W-1:0] lit(int idx, bit neg);
        logic [MASK_W-1:0] v = '0;
        v[2*idx + int'(neg)] = 1'b1;
        return v;
    endfunction

    function automatic logic [MASK_W-1:0] rand_mask();
        logic [MASK_W-1:0] v = '0;
        if ($urandom % 8 == 0) return v;
        for (int i = 0; i < NUM_IN; i++) begin
            int r = $urandom % 12;
            if (r == 0) v[2*i] = 1'b1;
            else if (r == 1) v[2*i+1] = 1'b1;
        end
        return v;
    endfunction

    function automatic plb_cfg_t rand_cfg();
        plb_cfg_t c;
        for (int t = 0; t < NUM_PT; t++) c.masks[t] = rand_mask();
        c.reg_mode  = 4'($urandom);
        c.wide_mode = 4'($urandom);
        c.ck_sel    = ck_sel_e'($urandom % 4);
        return c;
    endfunction

    task automatic chk(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        for (int m = 0; m < NUM_MC; m++)
            chk(tag, mc_out[m], cfg_m.reg_mode[m] ? q_m[m] : b_logic(cfg_m, m, din));
        chk(tag, oe_out, b_term(cfg_m.masks[PT_OE], din));
    endtask

    task automatic check_rand();
        for (int m = 0; m < NUM_MC; m++) begin
            if (cfg_m.reg_mode[m])
                chk("R5", mc_out[m], q_m[m]);
            else if (cfg_m.wide_mode[m])
                chk("R3", mc_out[m], b_logic(cfg_m, m, din));
            else
                chk("R2", mc_out[m], b_logic(cfg_m, m, din));
        end
        chk("R10", oe_out, b_term(cfg_m.masks[PT_OE], din));
    endtask

    task automatic tick();
        logic [NUM_MC-1:0] nq = q_m;
        bit pt = b_term(cfg_m.masks[PT_CK], din);
        bit en = (cfg_m.ck_sel == CK_PT) ? (pt && !prev_m) : y_en[int'(cfg_m.ck_sel)];
        bit clr = rst || !glob_rst_n || b_term(cfg_m.masks[PT_RST], din);
        bit nprev = rst ? 0 : pt;
        plb_cfg_t ncfg = rst ? '0 : (cfg_load ? cfg_in : cfg_m);
        for (int m = 0; m < NUM_MC; m++) begin
            if (clr) nq[m] = 1'b0;
            else if (en) nq[m] = b_logic(cfg_m, m, din);
        end
        @(posedge clk);
        q_m = nq; prev_m = nprev; cfg_m = ncfg;
        @(negedge clk);
    endtask

    task automatic load(plb_cfg_t c);
        cfg_in = c; cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic drive(logic [NUM_IN-1:0] x, logic [NUM_Y-1:0] y);
        din = x; y_en = y;
        #1;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        plb_cfg_t c;
        void'($urandom(32'd4242));
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        drive(18'h3ffff, 3'b111);
        check_all("R11");
        tick();
        check_all("R11");

        // R1: unused and contradictory terms stay low
        c = '0;
        c.masks[0] = lit(0, 0) | lit(0, 1);
        c.masks[5] = lit(1, 0) | lit(2, 1);
        load(c);
        drive(18'h00001, 3'b000); check_all("R1");
        drive(18'h3fffe, 3'b000); check_all("R1");
        drive(18'h00002, 3'b000); check_all("R1");
        chk("R1", mc_out[1], 1'b1);

        // R2 / R3: bypass ignores XOR term, wide inverts with it
        c = '0;
        c.masks[5] = lit(2, 0);
        c.masks[9] = lit(3, 0);
        c.masks[PT_OE] = lit(4, 1);
        load(c);
        drive(18'h0000c, 3'b000); check_all("R2"); chk("R2", mc_out[1], 1'b1);
        c.wide_mode[1] = 1'b1;
        // R11: load pending, old configuration still in force
        cfg_in = c; cfg_load = 1'b1; #1;
        chk("R11", mc_out[1], 1'b1);
        tick(); cfg_load = 1'b0;
        drive(18'h0000c, 3'b000); check_all("R3"); chk("R3", mc_out[1], 1'b0);
        drive(18'h00004, 3'b000); check_all("R3"); chk("R3", mc_out[1], 1'b1);
        drive(18'h00008, 3'b000); check_all("R3"); chk("R3", mc_out[1], 1'b1);
        // R10 and R4: combinatorial follow without an edge
        drive(18'h00000, 3'b000); chk("R10", oe_out, 1'b1);
        drive(18'h00010, 3'b000); chk("R10", oe_out, 1'b0);
        drive(18'h00004, 3'b000); chk("R4", mc_out[1], 1'b1);
        drive(18'h00000, 3'b000); chk("R4", mc_out[1], 1'b0);

        // R5 / R6: registered mode on dedicated clock 1
        c = '0;
        c.masks[0] = lit(1, 0);
        c.reg_mode[0] = 1'b1;
        c.ck_sel = CK_Y1;
        c.masks[PT_RST] = lit(5, 0);
        load(c);
        drive(18'h00002, 3'b101); tick(); check_all("R6"); chk("R6", mc_out[0], 1'b0);
        drive(18'h00002, 3'b010); chk("R5", mc_out[0], 1'b0);
        tick(); check_all("R5"); chk("R5", mc_out[0], 1'b1);
        drive(18'h00000, 3'b101); tick(); chk("R5", mc_out[0], 1'b1);
        // R8: global reset wins over a due capture
        drive(18'h00002, 3'b010); glob_rst_n = 1'b0; #1;
        tick(); glob_rst_n = 1'b1; check_all("R8"); chk("R8", mc_out[0], 1'b0);
        drive(18'h00002, 3'b010); tick(); chk("R5", mc_out[0], 1'b1);
        // R9: reset term clears the register
        drive(18'h00022, 3'b010); tick(); check_all("R9"); chk("R9", mc_out[0], 1'b0);

        // R7: capture on the term clock's rising step only
        c.ck_sel = CK_PT;
        c.masks[PT_CK] = lit(0, 0);
        load(c);
        drive(18'h00000, 3'b111); tick(); check_all("R7");
        drive(18'h00003, 3'b000); tick(); check_all("R7"); chk("R7", mc_out[0], 1'b1);
        drive(18'h00001, 3'b000); tick(); check_all("R7"); chk("R7", mc_out[0], 1'b1);
        drive(18'h00000, 3'b000); tick(); check_all("R7"); chk("R7", mc_out[0], 1'b1);
        drive(18'h00001, 3'b000); tick(); check_all("R7"); chk("R7", mc_out[0], 1'b0);

        // Random configurations and stimulus against the model
        for (int k = 0; k < 40; k++) begin
            load(rand_cfg());
            for (int n = 0; n < 25; n++) begin
                glob_rst_n = ($urandom % 16 != 0);
                drive(18'($urandom), 3'($urandom));
                check_rand();
                tick();
            end
            glob_rst_n = 1'b1;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule